// File: doc/BRIEF.md
# Synchronous Burst Command Front End

This block is the clocked command decoder that sits in front of a burst-capable synchronous SRAM array. On every rising clock edge it samples three chip enables, two address strobes (a processor-side strobe and a controller-side strobe), a burst advance input, the global-write and byte-write controls, and the external address. From these it classifies the cycle as a deselect, the start of a read or write burst, a burst continuation, or a burst suspension.

The low two address bits come from a small burst counter. The counter is preset from the external address when a burst begins, and it then walks either in linear order or in interleaved order, as selected by a mode input. The upper address bits stay fixed for the whole burst.

Every result is registered: the array address, a read strobe, a per-byte write mask and a command-class code that the output stage uses. When the processor strobe is held inactive and the controller strobe is held active, the block loads a fresh address on every cycle, which gives plain single-beat access.

Top module: `burst_cmd_frontend`

## Requirements
- R1: When a burst begins, the array address equals the sampled external address. During continuation cycles the upper bits (above bit 1) do not change. After four advances the address is back at the starting value.
- R2: With `burst_ilv` low (linear order), the low two bits follow (start + step) modulo 4, where the step is the number of advances since the burst began.
- R3: With `burst_ilv` high (interleaved order), the low two bits equal start XOR step.
- R4: `strb_cpu_n` low together with `en1_n` low, `en2` high and `en3_n` low begins a read burst whatever the write inputs are: `rd_stb`=1 and `wr_mask`=0. When `en1_n` is high, `strb_cpu_n` is masked and the cycle is decoded as if that strobe were high.
- R5: `strb_ctl_n` low with the device enabled (`en1_n` low, `en2` high, `en3_n` low) begins a read or a write burst, as the write decode selects. If the processor strobe is also live, it wins and the cycle is a read.
- R6: A live address strobe without full enable is a deselect: class 0, `rd_stb`=0, `wr_mask`=0, and the address is held. The burst ends, and later continue or suspend cycles stay deselected until the next begin. `en2` and `en3_n` have no effect in cycles with no strobe asserted.
- R7: With no live strobe and an active burst, `adv_n` low moves to the next burst address and `adv_n` high keeps the current address. Each such cycle is a read or a write as the write decode selects.
- R8: Write decode: `gwr_n` low writes all bytes (`wr_mask` all ones). Otherwise `bwe_n` low sets `wr_mask[i]` for each `bsel_n[i]` that is low. If no byte is selected, the cycle is a read.
- R9: Outputs change only at the clock edge that samples the inputs. `cmd_cls` codes: 0 deselect/idle, 1 begin read, 2 begin write, 3 continue read, 4 continue write, 5 suspend read, 6 suspend write.
- R10: While `rst_n` is low, all outputs are zero and no burst is active.
- R11: With `strb_cpu_n` held high and `strb_ctl_n` held low, every cycle begins a new access at the address sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en1_n | input | 1 | Primary chip enable, active low; also masks the processor strobe |
| en2 | input | 1 | Secondary chip enable, active high |
| en3_n | input | 1 | Secondary chip enable, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low, always a read |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, all bytes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | NBYTES | Per-byte write selects, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External address |
| arr_addr | output | ADDR_W | Registered array address |
| rd_stb | output | 1 | Registered read strobe |
| wr_mask | output | NBYTES | Registered per-byte write mask |
| cmd_cls | output | 3 | Registered command class code |

## Verification
Two functions can fall in the same cycle. One pair is strobe priority against write decode: a live processor strobe combined with an active global write and a live controller strobe. The bench checks that the cycle is a plain begin-read with an empty mask. The other pair is enable masking against burst continuation: the processor strobe is pulled low while `en1_n` is high during an active burst. The bench expects a continuation to the next counter address, not a new begin. Separate cases apply each burst order through a full five-address walk, so that the wrap to the start is observed.

// File: rtl/bfe_pkg.sv
package bfe_pkg;

    typedef enum logic [2:0] {
        CLS_IDLE     = 3'd0,
        CLS_RD_BEGIN = 3'd1,
        CLS_WR_BEGIN = 3'd2,
        CLS_RD_NEXT  = 3'd3,
        CLS_WR_NEXT  = 3'd4,
        CLS_RD_HOLD  = 3'd5,
        CLS_WR_HOLD  = 3'd6
    } cmd_cls_e;

    typedef enum logic [1:0] {
        ACT_DESEL = 2'd0,
        ACT_BEGIN = 2'd1,
        ACT_NEXT  = 2'd2,
        ACT_HOLD  = 2'd3
    } act_e;

endpackage

// File: rtl/bfe_decode.sv
module bfe_decode
    import bfe_pkg::*;
(
    input  logic en1_n,
    input  logic en2,
    input  logic en3_n,
    input  logic strb_cpu_n,
    input  logic strb_ctl_n,
    input  logic adv_n,
    output act_e kind,
    output logic force_rd
);
    logic cpu_live;
    logic enabled;

    assign cpu_live = !strb_cpu_n && !en1_n;
    assign enabled  = !en1_n && en2 && !en3_n;

    always_comb begin
        kind     = ACT_HOLD;
        force_rd = 1'b0;
        if (cpu_live) begin
            // processor strobe has priority and always reads
            kind     = enabled ? ACT_BEGIN : ACT_DESEL;
            force_rd = 1'b1;
        end else if (!strb_ctl_n) begin
            kind = enabled ? ACT_BEGIN : ACT_DESEL;
        end else begin
            kind = adv_n ? ACT_HOLD : ACT_NEXT;
        end
    end
endmodule

// File: rtl/bfe_wmask.sv
module bfe_wmask #(
    parameter int NBYTES = 8
) (
    input  logic              gwr_n,
    input  logic              bwe_n,
    input  logic [NBYTES-1:0] bsel_n,
    output logic [NBYTES-1:0] mask,
    output logic              any_wr
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign mask[i] = !gwr_n || (!bwe_n && !bsel_n[i]);
    end

    assign any_wr = |mask;
endmodule

// File: rtl/bfe_burst_seq.sv
module bfe_burst_seq #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] step,
    input  logic             ilv,
    output logic [CNT_W-1:0] low
);
    logic [CNT_W-1:0] lin_val;
    logic [CNT_W-1:0] ilv_val;

    assign lin_val = start + step;
    assign ilv_val = start ^ step;
    assign low     = ilv ? ilv_val : lin_val;
endmodule

// File: rtl/burst_cmd_frontend.sv
module burst_cmd_frontend
    import bfe_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int NBYTES = 8,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en1_n,
    input  logic              en2,
    input  logic              en3_n,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              gwr_n,
    input  logic              bwe_n,
    input  logic [NBYTES-1:0] bsel_n,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              rd_stb,
    output logic [NBYTES-1:0] wr_mask,
    output logic [2:0]        cmd_cls
);
    localparam int HI_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  step;
        logic              active;
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic [NBYTES-1:0] mask;
        cmd_cls_e          cls;
    } fe_state_t;

    fe_state_t st_d, st_q;

    act_e              kind;
    logic              force_rd;
    logic [NBYTES-1:0] raw_mask;
    logic              any_wr;
    logic [CNT_W-1:0]  step_sel;
    logic [CNT_W-1:0]  seq_low;

    bfe_decode i_decode (
        .en1_n      (en1_n),
        .en2        (en2),
        .en3_n      (en3_n),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .adv_n      (adv_n),
        .kind       (kind),
        .force_rd   (force_rd)
    );

    bfe_wmask #(.NBYTES(NBYTES)) i_wmask (
        .gwr_n  (gwr_n),
        .bwe_n  (bwe_n),
        .bsel_n (bsel_n),
        .mask   (raw_mask),
        .any_wr (any_wr)
    );

    assign step_sel = (kind == ACT_NEXT) ? st_q.step + CNT_W'(1) : st_q.step;

    bfe_burst_seq #(.CNT_W(CNT_W)) i_seq (
        .start (st_q.base[CNT_W-1:0]),
        .step  (step_sel),
        .ilv   (burst_ilv),
        .low   (seq_low)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rd   = 1'b0;
        st_d.mask = '0;
        st_d.cls  = CLS_IDLE;
        unique case (kind)
            ACT_DESEL: begin
                st_d.active = 1'b0;
            end
            ACT_BEGIN: begin
                st_d.base   = addr_in;
                st_d.step   = '0;
                st_d.active = 1'b1;
                st_d.addr   = addr_in;
                if (force_rd || !any_wr) begin
                    st_d.rd  = 1'b1;
                    st_d.cls = CLS_RD_BEGIN;
                end else begin
                    st_d.mask = raw_mask;
                    st_d.cls  = CLS_WR_BEGIN;
                end
            end
            ACT_NEXT, ACT_HOLD: begin
                if (st_q.active) begin
                    st_d.step = step_sel;
                    st_d.addr = {st_q.base[ADDR_W-1 -: HI_W], seq_low};
                    if (!any_wr) begin
                        st_d.rd  = 1'b1;
                        st_d.cls = (kind == ACT_NEXT) ? CLS_RD_NEXT : CLS_RD_HOLD;
                    end else begin
                        st_d.mask = raw_mask;
                        st_d.cls  = (kind == ACT_NEXT) ? CLS_WR_NEXT : CLS_WR_HOLD;
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign arr_addr = st_q.addr;
    assign rd_stb   = st_q.rd;
    assign wr_mask  = st_q.mask;
    assign cmd_cls  = st_q.cls;
endmodule

// File: rtl/bfe_chk.sv
module bfe_chk #(
    parameter int ADDR_W = 18,
    parameter int NBYTES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en1_n,
    input logic              en2,
    input logic              en3_n,
    input logic              strb_cpu_n,
    input logic              strb_ctl_n,
    input logic              adv_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              rd_stb,
    input logic [NBYTES-1:0] wr_mask,
    input logic [2:0]        cmd_cls
);
    logic cpu_begin;
    logic no_strobe;

    assign cpu_begin = !strb_cpu_n && !en1_n && en2 && !en3_n;
    assign no_strobe = strb_cpu_n && strb_ctl_n;

    AST_CPU_BEGIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_begin |=> (arr_addr == $past(addr_in)) && rd_stb && (wr_mask == '0)); // R4

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && (wr_mask != '0))); // R8

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_cls == 3'd0) |-> (!rd_stb && (wr_mask == '0))); // R6

    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && adv_n && (cmd_cls != 3'd0)) |=> (arr_addr == $past(arr_addr))); // R7

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && !adv_n && (cmd_cls != 3'd0))
        |=> (arr_addr[ADDR_W-1:2] == $past(arr_addr[ADDR_W-1:2]))); // R1

    AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cls != 3'd7); // R9
endmodule

bind burst_cmd_frontend bfe_chk #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) i_bfe_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en1_n      (en1_n),
    .en2        (en2),
    .en3_n      (en3_n),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .adv_n      (adv_n),
    .addr_in    (addr_in),
    .arr_addr   (arr_addr),
    .rd_stb     (rd_stb),
    .wr_mask    (wr_mask),
    .cmd_cls    (cmd_cls)
);

// File: tb/test_burst_cmd_frontend.sv
module test_burst_cmd_frontend;
    localparam int CLK_P = 10;
    localparam int AW    = 18;
    localparam int NB    = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en1_n, en2, en3_n;
    logic          strb_cpu_n, strb_ctl_n, adv_n;
    logic          gwr_n, bwe_n;
    logic [NB-1:0] bsel_n;
    logic          burst_ilv;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] arr_addr;
    logic          rd_stb;
    logic [NB-1:0] wr_mask;
    logic [2:0]    cmd_cls;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_P/2) clk = ~clk;

    burst_cmd_frontend #(.ADDR_W(AW), .NBYTES(NB)) i_burst_cmd_frontend (
        .clk(clk), .rst_n(rst_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .gwr_n(gwr_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .burst_ilv(burst_ilv),
        .addr_in(addr_in), .arr_addr(arr_addr), .rd_stb(rd_stb),
        .wr_mask(wr_mask), .cmd_cls(cmd_cls)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below 5000", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_inputs();
        en1_n = 1'b0; en2 = 1'b1; en3_n = 1'b0;
        strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
        gwr_n = 1'b1; bwe_n = 1'b1; bsel_n = '1;
    endtask

    task automatic chk(string req, logic [AW-1:0] ea, logic er, logic [NB-1:0] em, logic [2:0] ec);
        n_chk++;
        if (arr_addr !== ea || rd_stb !== er || wr_mask !== em || cmd_cls !== ec) begin
            n_bad++;
            $display("FAIL %s: addr=%h rd=%b mask=%h cls=%0d expected addr=%h rd=%b mask=%h cls=%0d",
                     req, arr_addr, rd_stb, wr_mask, cmd_cls, ea, er, em, ec);
        end
    endtask

    task automatic ctl_begin(logic [AW-1:0] a);
        idle_inputs();
        strb_ctl_n = 1'b0;
        addr_in    = a;
        tick();
        idle_inputs();
    endtask

    task automatic advance();
        idle_inputs();
        adv_n = 1'b0;
        tick();
        idle_inputs();
    endtask

    task automatic t_reset();
        chk("R10 reset", '0, 1'b0, '0, 3'd0);
    endtask

    task automatic t_linear();
        burst_ilv = 1'b0;
        ctl_begin(18'h1F3E6);
        chk("R1 R9 begin read", 18'h1F3E6, 1'b1, '0, 3'd1);
        advance(); chk("R2 step1", 18'h1F3E7, 1'b1, '0, 3'd3);
        advance(); chk("R2 step2", 18'h1F3E4, 1'b1, '0, 3'd3);
        advance(); chk("R2 step3", 18'h1F3E5, 1'b1, '0, 3'd3);
        advance(); chk("R1 wrap fifth", 18'h1F3E6, 1'b1, '0, 3'd3);
    endtask

    task automatic t_interleave();
        burst_ilv = 1'b1;
        ctl_begin(18'h2A5C1);
        chk("R3 begin", 18'h2A5C1, 1'b1, '0, 3'd1);
        advance(); chk("R3 step1", 18'h2A5C0, 1'b1, '0, 3'd3);
        advance(); chk("R3 step2", 18'h2A5C3, 1'b1, '0, 3'd3);
        advance(); chk("R3 step3", 18'h2A5C2, 1'b1, '0, 3'd3);
        advance(); chk("R3 wrap fifth", 18'h2A5C1, 1'b1, '0, 3'd3);
    endtask

    task automatic t_suspend();
        idle_inputs();
        tick(); chk("R7 suspend read", 18'h2A5C1, 1'b1, '0, 3'd5);
        gwr_n = 1'b0;
        tick(); chk("R7 suspend write", 18'h2A5C1, 1'b0, 8'hFF, 3'd6);
        adv_n = 1'b0;
        tick(); chk("R7 continue write", 18'h2A5C0, 1'b0, 8'hFF, 3'd4);
        idle_inputs();
        adv_n = 1'b0; en2 = 1'b0;
        tick(); chk("R6 en2 ignored without strobe", 18'h2A5C3, 1'b1, '0, 3'd3);
        idle_inputs();
    endtask

    task automatic t_cpu();
        idle_inputs();
        strb_cpu_n = 1'b0; gwr_n = 1'b0; addr_in = 18'h00104;
        tick(); chk("R4 cpu read ignores write", 18'h00104, 1'b1, '0, 3'd1);
        idle_inputs();
        en1_n = 1'b1; strb_cpu_n = 1'b0; adv_n = 1'b0; addr_in = 18'h3FFFF;
        tick(); chk("R4 en1 masks cpu strobe", 18'h00105, 1'b1, '0, 3'd3);
        idle_inputs();
    endtask

    task automatic t_ctl_write();
        burst_ilv = 1'b0;
        idle_inputs();
        strb_ctl_n = 1'b0; bwe_n = 1'b0; bsel_n = 8'hFA; addr_in = 18'h03008;
        tick(); chk("R5 R8 byte write", 18'h03008, 1'b0, 8'h05, 3'd2);
        idle_inputs();
        strb_ctl_n = 1'b0; gwr_n = 1'b0; bsel_n = 8'hFF; addr_in = 18'h03010;
        tick(); chk("R8 global write", 18'h03010, 1'b0, 8'hFF, 3'd2);
        idle_inputs();
        strb_ctl_n = 1'b0; bwe_n = 1'b0; addr_in = 18'h03020;
        tick(); chk("R8 no byte selected reads", 18'h03020, 1'b1, '0, 3'd1);
        idle_inputs();
    endtask

    task automatic t_priority();
        idle_inputs();
        strb_cpu_n = 1'b0; strb_ctl_n = 1'b0; gwr_n = 1'b0; addr_in = 18'h0ABC0;
        tick(); chk("R5 cpu strobe wins", 18'h0ABC0, 1'b1, '0, 3'd1);
        idle_inputs();
    endtask

    task automatic t_desel();
        idle_inputs();
        strb_ctl_n = 1'b0; en3_n = 1'b1; addr_in = 18'h12345;
        tick(); chk("R6 deselect", 18'h0ABC0, 1'b0, '0, 3'd0);
        idle_inputs();
        adv_n = 1'b0;
        tick(); chk("R6 no continue after deselect", 18'h0ABC0, 1'b0, '0, 3'd0);
        idle_inputs();
        tick(); chk("R6 no suspend after deselect", 18'h0ABC0, 1'b0, '0, 3'd0);
        ctl_begin(18'h00200);
        chk("R5 begin after deselect", 18'h00200, 1'b1, '0, 3'd1);
        idle_inputs();
        en1_n = 1'b1; strb_ctl_n = 1'b0; addr_in = 18'h00300;
        tick(); chk("R6 en1 high with ctl strobe", 18'h00200, 1'b0, '0, 3'd0);
        idle_inputs();
    endtask

    task automatic t_plain();
        idle_inputs();
        strb_ctl_n = 1'b0; adv_n = 1'b0;
        addr_in = 18'h00011;
        #1; chk("R9 no change before edge", 18'h00200, 1'b0, '0, 3'd0);
        tick(); chk("R11 plain a", 18'h00011, 1'b1, '0, 3'd1);
        addr_in = 18'h00022;
        tick(); chk("R11 plain b", 18'h00022, 1'b1, '0, 3'd1);
        addr_in = 18'h00033; bwe_n = 1'b0; bsel_n = 8'h7F;
        tick(); chk("R11 plain write", 18'h00033, 1'b0, 8'h80, 3'd2);
        idle_inputs();
    endtask

    initial begin
        idle_inputs();
        burst_ilv = 1'b1;
        addr_in   = '0;
        rst_n     = 1'b0;
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        chk("R10 idle after reset", '0, 1'b0, '0, 3'd0);
        t_linear();
        t_interleave();
        t_suspend();
        t_cpu();
        t_ctl_write();
        t_priority();
        t_desel();
        t_plain();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule